// File: doc/BRIEF.md
# Configurable FPGA Logic Cell

This block is one programmable logic cell of the kind tiled inside a larger logic block. A set of static configuration inputs programs it. A 16-entry truth table sets up a 4-input function generator. A mode field picks how the carry logic behaves. Two further bits pick the storage element's data source and whether that element acts as an edge-triggered flip-flop or a level-sensitive latch. The user datapath runs alongside: four function inputs, a direct data input, a chain input from the neighbouring cell, a clock enable, a clock and an asynchronous clear.

The cell has three independent outputs: combinational, registered and feedthrough. The feedthrough output repeats the direct data input, so that input can also be routed onwards while the function generator and the storage element do other work. The chain logic works in one of two ways. In arithmetic mode it forms a carry. In cascade mode it ANDs or ORs the function result with the incoming chain value, so that several stacked cells can decode very wide functions.

Top module: `cfg_logic_cell`

## Requirements
- R1: With chain mode 2'b11 (plain), combOut equals cfgTable[fnIn], where fnIn is used as an unsigned index and fnIn[0] is its least significant bit.
- R2: feedOut always equals directIn, whatever the configuration, the function inputs and the storage state.
- R3: With chain mode 2'b00 (arithmetic), combOut is cfgTable[fnIn] XOR carryIn, and carryOut is the majority of fnIn[0], fnIn[1] and carryIn.
- R4: With chain mode 2'b01 (cascade AND), combOut and carryOut both equal cfgTable[fnIn] AND carryIn.
- R5: With chain mode 2'b10 (cascade OR), combOut and carryOut both equal cfgTable[fnIn] OR carryIn.
- R6: With chain mode 2'b11, carryOut equals carryIn.
- R7: The storage data input is directIn when cfgDinSel is 1 and combOut when cfgDinSel is 0.
- R8: With cfgLatch at 0, regOut takes the storage data input on a rising clk edge where ce is 1. It holds its value when ce is 0, and it ignores changes to the data input while clk is high.
- R9: With cfgLatch at 1, regOut follows the storage data input while clk is high and ce is 1, and holds its value while clk is low.
- R10: While clear is 1, regOut is 0 at once, without waiting for a clock, in both storage modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgTable | input | 16 | Truth table of the function generator |
| cfgLatch | input | 1 | 1 = latch storage, 0 = flip-flop storage |
| cfgDinSel | input | 1 | 1 = store directIn, 0 = store combOut |
| cfgChain | input | 2 | Chain mode: 00 arithmetic, 01 cascade AND, 10 cascade OR, 11 plain |
| fnIn | input | 4 | Function generator inputs |
| directIn | input | 1 | Direct data input |
| carryIn | input | 1 | Incoming carry or cascade value |
| ce | input | 1 | Clock enable of the storage element |
| clk | input | 1 | Clock, also the latch gate |
| clear | input | 1 | Asynchronous clear, active high |
| combOut | output | 1 | Combinational result |
| regOut | output | 1 | Stored result |
| feedOut | output | 1 | Direct feedthrough of directIn |
| carryOut | output | 1 | Carry or cascade output to the next cell |

## Verification
The clocked properties assume three things about the inputs. The configuration and data inputs change only while clk is low. clear keeps one value across each rising edge. When clear is pulsed between edges, the cell is in latch mode, so the flip-flop load and hold properties do not apply. The stimulus meets these assumptions: every input is driven one nanosecond after a falling edge, and the asynchronous-clear case is run with cfgLatch at 1. Latch transparency is checked by changing directIn in the middle of the high phase, which the properties never sample.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    CHAIN_ARITH   = 2'b00,
    CHAIN_CASCAND = 2'b01,
    CHAIN_CASCOR  = 2'b10,
    CHAIN_PLAIN   = 2'b11
  } chainMode_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic arith;
    logic cascAnd;
    logic cascOr;
    logic plain;
    logic pickDirect;
    logic latchMode;
    logic ffLoad;
    logic latchOpen;
  } cellStrobe_t;

endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic        clk,
  input  logic        ce,
  input  logic        cfgLatch,
  input  logic        cfgDinSel,
  input  logic [1:0]  cfgChain,
  output cellStrobe_t strobe
);

  chainMode_e mode;

  always_comb begin
    mode = chainMode_e'(cfgChain);
    strobe = '0;
    unique case (mode)
      CHAIN_ARITH:   strobe.arith   = 1'b1;
      CHAIN_CASCAND: strobe.cascAnd = 1'b1;
      CHAIN_CASCOR:  strobe.cascOr  = 1'b1;
      default:       strobe.plain   = 1'b1;
    endcase
    strobe.pickDirect = cfgDinSel;
    strobe.latchMode  = cfgLatch;
    strobe.ffLoad     = ce;
    // both storage elements track the data; the mode bit only picks the output
    strobe.latchOpen  = clk & ce;
  end

endmodule

// File: rtl/lcell_datapath.sv
module lcell_datapath
  import lcell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  localparam int TABLE_BITS = 1 << LUT_INPUTS
) (
  input  logic                  clk,
  input  logic                  clear,
  input  cellStrobe_t           strobe,
  input  logic [TABLE_BITS-1:0] cfgTable,
  input  logic [LUT_INPUTS-1:0] fnIn,
  input  logic                  directIn,
  input  logic                  carryIn,
  output logic                  combOut,
  output logic                  regOut,
  output logic                  feedOut,
  output logic                  carryOut
);

  logic lutOut;
  logic majority;
  logic storeD;
  logic ffQ;
  logic latchQ;

  assign lutOut = cfgTable[fnIn];

  generate
    if (LUT_INPUTS >= 2) begin : g_maj2
      assign majority = (fnIn[0] & fnIn[1]) | (fnIn[0] & carryIn) | (fnIn[1] & carryIn);
    end else begin : g_maj1
      assign majority = fnIn[0] & carryIn;
    end
  endgenerate

  always_comb begin
    combOut  = lutOut;
    carryOut = carryIn;
    if (strobe.arith) begin
      combOut  = lutOut ^ carryIn;
      carryOut = majority;
    end else if (strobe.cascAnd) begin
      combOut  = lutOut & carryIn;
      carryOut = lutOut & carryIn;
    end else if (strobe.cascOr) begin
      combOut  = lutOut | carryIn;
      carryOut = lutOut | carryIn;
    end
  end

  assign storeD  = strobe.pickDirect ? directIn : combOut;
  assign feedOut = directIn;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) ffQ <= 1'b0;
    else if (strobe.ffLoad) ffQ <= storeD;
  end

  always_latch begin
    if (clear) latchQ <= 1'b0;
    else if (strobe.latchOpen) latchQ <= storeD;
  end

  assign regOut = strobe.latchMode ? latchQ : ffQ;

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lcell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  localparam int TABLE_BITS = 1 << LUT_INPUTS
) (
  input  logic [TABLE_BITS-1:0] cfgTable,
  input  logic                  cfgLatch,
  input  logic                  cfgDinSel,
  input  logic [1:0]            cfgChain,
  input  logic [LUT_INPUTS-1:0] fnIn,
  input  logic                  directIn,
  input  logic                  carryIn,
  input  logic                  ce,
  input  logic                  clk,
  input  logic                  clear,
  output logic                  combOut,
  output logic                  regOut,
  output logic                  feedOut,
  output logic                  carryOut
);

  cellStrobe_t strobe;

  lcell_ctrl u_ctrl (
    .clk       (clk),
    .ce        (ce),
    .cfgLatch  (cfgLatch),
    .cfgDinSel (cfgDinSel),
    .cfgChain  (cfgChain),
    .strobe    (strobe)
  );

  lcell_datapath #(.LUT_INPUTS(LUT_INPUTS)) u_dp (
    .clk      (clk),
    .clear    (clear),
    .strobe   (strobe),
    .cfgTable (cfgTable),
    .fnIn     (fnIn),
    .directIn (directIn),
    .carryIn  (carryIn),
    .combOut  (combOut),
    .regOut   (regOut),
    .feedOut  (feedOut),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/lcell_checker.sv
module lcell_checker #(
  parameter int LUT_INPUTS = 4,
  localparam int TABLE_BITS = 1 << LUT_INPUTS
) (
  input logic [TABLE_BITS-1:0] cfgTable,
  input logic                  cfgLatch,
  input logic                  cfgDinSel,
  input logic [1:0]            cfgChain,
  input logic [LUT_INPUTS-1:0] fnIn,
  input logic                  directIn,
  input logic                  carryIn,
  input logic                  ce,
  input logic                  clk,
  input logic                  clear,
  input logic                  combOut,
  input logic                  regOut,
  input logic                  feedOut,
  input logic                  carryOut
);

  // R8: a flip-flop load takes the selected data
  assert_ff_load_R8: assert property (@(posedge clk) disable iff (clear)
    (!cfgLatch && ce) |=> (cfgLatch || regOut == $past(cfgDinSel ? directIn : combOut)));

  // R8: without enable the flip-flop holds
  assert_ff_hold_R8: assert property (@(posedge clk) disable iff (clear)
    (!cfgLatch && !ce) |=> (cfgLatch || $stable(regOut)));

  // R3: arithmetic carry is the majority of two operands and carry-in
  assert_arith_carry_R3: assert property (@(posedge clk) disable iff (clear)
    (cfgChain == 2'b00) |->
      (carryOut == ((fnIn[0] & fnIn[1]) | (fnIn[0] & carryIn) | (fnIn[1] & carryIn))));

  // R4: a low chain input forces the AND cascade low
  assert_casc_and_R4: assert property (@(posedge clk) disable iff (clear)
    (cfgChain == 2'b01 && !carryIn) |-> (!carryOut && !combOut));

  // R5: a high chain input forces the OR cascade high
  assert_casc_or_R5: assert property (@(posedge clk) disable iff (clear)
    (cfgChain == 2'b10 && carryIn) |-> (carryOut && combOut));

  // R6: plain mode passes the chain through
  assert_plain_pass_R6: assert property (@(posedge clk) disable iff (clear)
    (cfgChain == 2'b11) |-> (carryOut == carryIn));

  // R10: clear dominates the stored value
  always @(posedge clk) begin
    if (clear) assert_clear_zero_R10: assert (regOut == 1'b0);
  end

endmodule

bind cfg_logic_cell lcell_checker #(.LUT_INPUTS(LUT_INPUTS)) u_chk (.*);

// File: tb/test_cfg_logic_cell.sv
module test_cfg_logic_cell;

  logic [15:0] cfgTable;
  logic        cfgLatch, cfgDinSel;
  logic [1:0]  cfgChain;
  logic [3:0]  fnIn;
  logic        directIn, carryIn, ce, clk, clear;
  logic        combOut, regOut, feedOut, carryOut;

  int vectors = 0;
  int fails = 0;
  bit refQ;

  cfg_logic_cell i_cfg_logic_cell (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic bit refLut();
    int idx = int'(fnIn);
    return cfgTable[idx];
  endfunction

  function automatic bit refComb();
    case (cfgChain)
      2'b00:   return refLut() ^ carryIn;
      2'b01:   return refLut() & carryIn;
      2'b10:   return refLut() | carryIn;
      default: return refLut();
    endcase
  endfunction

  function automatic bit refCarry();
    int ones = int'(fnIn[0]) + int'(fnIn[1]) + int'(carryIn);
    case (cfgChain)
      2'b00:   return ones >= 2;
      2'b01:   return refLut() & carryIn;
      2'b10:   return refLut() | carryIn;
      default: return carryIn;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string combTag();
    case (cfgChain)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic string carryTag();
    case (cfgChain)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // inputs were driven in the low phase; compare in the middle of the high phase
  task automatic runStep();
    @(posedge clk);
    #2;
    if (clear) refQ = 1'b0;
    else if (ce) refQ = cfgDinSel ? directIn : refComb();   // R7
    check(combTag(), combOut, refComb());
    check(carryTag(), carryOut, refCarry());
    check("R2", feedOut, directIn);
    check(cfgClear() ? "R10" : (cfgLatch ? "R9" : "R8"), regOut, refQ);
    @(negedge clk);
    #1;
  endtask

  function automatic bit cfgClear();
    return clear;
  endfunction

  initial begin
    cfgTable = 16'h6996; cfgLatch = 0; cfgDinSel = 0; cfgChain = 2'b11;
    fnIn = 0; directIn = 0; carryIn = 0; ce = 0; clear = 1;
    #1;
    check("R10", regOut, 1'b0);   // reset state
    runStep();
    clear = 0;

    // R1 plain lookup over every index
    for (int i = 0; i < 16; i++) begin
      cfgTable = 16'hA5C3; fnIn = 4'(i); carryIn = i[0]; directIn = i[1];
      ce = 1; cfgDinSel = i[2];
      runStep();
    end

    // R9 latch transparency in the high phase
    cfgLatch = 1; ce = 1; cfgDinSel = 1; directIn = 0;
    runStep();
    @(posedge clk); #1 directIn = 1; #1;
    check("R9", regOut, 1'b1);
    @(negedge clk); #1 directIn = 0; #1;
    check("R9", regOut, 1'b1);
    refQ = 1'b1;

    // R8 flip-flop ignores data changes in the high phase
    cfgLatch = 0; ce = 1; directIn = 0;
    runStep();
    @(posedge clk); #1 directIn = 1; #1;
    check("R8", regOut, 1'b0);
    @(negedge clk); #1;
    runStep();
    check("R8", regOut, 1'b1);

    // R10 asynchronous clear while clk is low, latch mode
    cfgLatch = 1; ce = 1; directIn = 1;
    runStep();
    ce = 0;
    #1 clear = 1;
    #1 check("R10", regOut, 1'b0);
    #1 clear = 0;
    refQ = 1'b0;
    runStep();

    // random patterns over all modes
    for (int n = 0; n < 600; n++) begin
      cfgTable  = 16'($urandom);
      cfgLatch  = 1'($urandom);
      cfgDinSel = 1'($urandom);
      cfgChain  = 2'($urandom);
      fnIn      = 4'($urandom);
      directIn  = 1'($urandom);
      carryIn   = 1'($urandom);
      ce        = 1'($urandom);
      clear     = ($urandom % 20) == 0;
      runStep();
    end
    clear = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule